// File: doc/BRIEF.md
# Cascadable Down-Counting Timer Pair

This block holds two programmable down-counters behind a byte-addressed, synchronous register port. The even channel is 24 bits wide and the odd channel 32 bits wide. Each channel picks one of four single-cycle tick enables, counts from a preset value down to zero, reloads itself, and reports that terminal count with a one-cycle interrupt pulse and a sticky flag. Software clears the flag by reading the control byte.

Setting the combine bit in the even channel's control byte chains the pair. The even channel then sets a period and reloads itself at each terminal count. Each of those terminal counts decrements the odd channel by one. In this mode the odd channel's observation register returns the complement of its count, so it reads as a value that rises over time. This pairing gives a long-running, fine-grained elapsed-time counter, such as one that advances once per microsecond for busy-wait loops.

Top module: `tmr_pair`

## Requirements
- R1: Register layout per channel n: control byte at 0x10+8n, tick-select byte at 0x11+8n (bits 1:0), 32-bit preset at 0x14+8n, 32-bit observation at 0x48+4n. A read returns the addressed register on rdata_o one cycle after rd_en_i. Unmapped addresses read zero. Control bits: 0 = enable, 1 = restart (always reads 0), 3 = combine, 7 = terminal-count flag.
- R2: A control write with bit 1 set loads the preset into the counter at that clock edge. With bit 0 set as well, counting starts from the preset.
- R3: An enabled channel decrements once per selected tick. At zero, the next tick is its terminal count and reloads the preset, so a preset of N gives a period of N+1 ticks.
- R4: Tick-select value s (0..3) makes only ticks_i[s] advance the channel.
- R5: With the enable bit cleared, the counter holds its value whatever ticks arrive.
- R6: On the 24-bit channel, preset bits above bit 23 are dropped and read back as zero. The 32-bit channel keeps all 32 bits.
- R7: Terminal count sets control bit 7. A read of that control byte clears it, and a set in the same cycle as the read wins.
- R8: Each terminal count gives a one-cycle high pulse on irq_o[n] in the cycle after the terminal tick's edge.
- R9: With the combine bit of the even channel set, the odd channel ignores its own tick source and decrements by exactly one on each terminal count of the even channel.
- R10: While combined, the odd channel's observation returns the bitwise complement of its count. The even channel's observation is not complemented.
- R11: A restart write in the same cycle as a tick loads the preset; the decrement is dropped.
- R12: The observation register is refreshed every clock from the counter, so a single read returns a full, coherent 32-bit value.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data, low bits used for byte registers |
| rdata_o | output | 32 | Registered read data |
| ticks_i | input | NUM_SRC | Single-cycle tick enables, one per source |
| irq_o | output | NUM_CH | Terminal-count pulse per channel |

## Verification
The assertions assume that a channel is never restarted while its preset is zero. They also assume that presets are at least one, so that two terminal counts can never fall in adjacent cycles. The stimulus writes a nonzero preset before every restart and drives each tick for a single cycle. Reads are issued only when no tick is pending, so every expected observation value is fixed by the ticks already applied.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
  localparam int unsigned NUM_SRC       = 4;
  localparam int unsigned SEL_W         = 2;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_RST_BIT  = 1;
  localparam int unsigned CTRL_COMB_BIT = 3;
  localparam int unsigned CTRL_TC_BIT   = 7;

  typedef enum logic [SEL_W-1:0] {
    SRC_32K  = 2'd0,
    SRC_1K   = 2'd1,
    SRC_32HZ = 2'd2,
    SRC_SYS  = 2'd3
  } tick_src_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [NSRC-1:0]  ticks_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (sel_i == SEL_W'(s)) tick_o = ticks_i[s];
    end
  end
endmodule

// File: rtl/tmr_chan_cfg.sv
module tmr_chan_cfg
  import tmr_pair_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_sel_i,
  input  logic             wr_preset_i,
  input  logic             rd_ctrl_i,
  input  logic [31:0]      wdata_i,
  input  logic             tc_i,
  output logic             en_o,
  output logic             load_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [W-1:0]     preset_o,
  output logic [7:0]       ctrl_o
);
  logic             en_q, comb_q, flag_q;
  logic [SEL_W-1:0] sel_q;
  logic [W-1:0]     preset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      comb_q   <= 1'b0;
      sel_q    <= '0;
      preset_q <= '0;
    end else begin
      if (wr_ctrl_i) begin
        en_q   <= wdata_i[CTRL_EN_BIT];
        comb_q <= wdata_i[CTRL_COMB_BIT];
      end
      if (wr_sel_i)    sel_q    <= wdata_i[SEL_W-1:0];
      if (wr_preset_i) preset_q <= wdata_i[W-1:0];
    end
  end

  // set beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (tc_i)      flag_q <= 1'b1;
    else if (rd_ctrl_i) flag_q <= 1'b0;
  end

  assign en_o     = en_q;
  assign load_o   = wr_ctrl_i & wdata_i[CTRL_RST_BIT];
  assign sel_o    = sel_q;
  assign preset_o = preset_q;
  assign ctrl_o   = {flag_q, 3'b000, comb_q, 2'b00, en_q};

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i |=> ctrl_o[CTRL_TC_BIT]);
  p_flag_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl_i && !tc_i) |=> !ctrl_o[CTRL_TC_BIT]);
  p_preset_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (preset_q != '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic         tick_i,
  input  logic         invert_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] count_o,
  output logic [31:0]  obs_o,
  output logic         tc_o,
  output logic         irq_o
);
  logic [W-1:0] cnt_q, cnt_d, cnt_inv;
  logic [31:0]  obs_q;
  logic         irq_q, adv, at_zero, tc, dec;

  assign adv     = en_i & tick_i & ~load_i;
  assign at_zero = (cnt_q == '0);
  assign tc      = adv & at_zero;
  assign dec     = adv & ~at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i || tc) cnt_d = preset_i;
    else if (dec)     cnt_d = cnt_q - W'(1);
  end
  assign cnt_inv = ~cnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      obs_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      obs_q <= invert_i ? 32'(cnt_inv) : 32'(cnt_d);
      irq_q <= tc;
    end
  end

  assign count_o = cnt_q;
  assign obs_o   = obs_q;
  assign tc_o    = tc;
  assign irq_o   = irq_q;

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && !load_i && count_o == '0) |=> (count_o == $past(preset_i)));
  p_count_dn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && !load_i && count_o != '0) |=> (count_o == $past(count_o) - W'(1)));
  p_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(count_o));
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(preset_i)));
  p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned LOW_W       = 24,
  parameter int unsigned HIGH_W      = 32,
  parameter int unsigned CTRL_BASE   = 'h10,
  parameter int unsigned CTRL_STRIDE = 8,
  parameter int unsigned SEL_OFS     = 1,
  parameter int unsigned PRE_OFS     = 4,
  parameter int unsigned OBS_BASE    = 'h48,
  parameter int unsigned OBS_STRIDE  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_SRC-1:0] ticks_i,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] hit_ctrl, hit_sel, hit_pre, hit_obs;
  logic [NUM_CH-1:0] tc_w, en_w, load_w;
  logic [7:0]        ctrl_w   [NUM_CH];
  logic [SEL_W-1:0]  sel_w    [NUM_CH];
  logic [31:0]       preset32 [NUM_CH];
  logic [31:0]       obs32    [NUM_CH];
  logic [31:0]       cnt32    [NUM_CH];
  logic [31:0]       rd_mux, rdata_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int unsigned W = (i % 2 == 0) ? LOW_W : HIGH_W;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_BASE + i * CTRL_STRIDE);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(CTRL_BASE + i * CTRL_STRIDE + SEL_OFS);
    localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(CTRL_BASE + i * CTRL_STRIDE + PRE_OFS);
    localparam logic [ADDR_W-1:0] A_OBS  = ADDR_W'(OBS_BASE + i * OBS_STRIDE);

    logic [W-1:0] preset, cnt;
    logic         src_tick, ch_tick, invert;

    assign hit_ctrl[i] = (addr_i == A_CTRL);
    assign hit_sel[i]  = (addr_i == A_SEL);
    assign hit_pre[i]  = (addr_i == A_PRE);
    assign hit_obs[i]  = (addr_i == A_OBS);

    tmr_chan_cfg #(.W(W)) i_cfg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_ctrl_i   (wr_en_i & hit_ctrl[i]),
      .wr_sel_i    (wr_en_i & hit_sel[i]),
      .wr_preset_i (wr_en_i & hit_pre[i]),
      .rd_ctrl_i   (rd_en_i & hit_ctrl[i]),
      .wdata_i     (wdata_i),
      .tc_i        (tc_w[i]),
      .en_o        (en_w[i]),
      .load_o      (load_w[i]),
      .sel_o       (sel_w[i]),
      .preset_o    (preset),
      .ctrl_o      (ctrl_w[i])
    );

    tmr_tick_sel #(.NSRC(NUM_SRC), .SEL_W(SEL_W)) i_tsel (
      .ticks_i (ticks_i),
      .sel_i   (sel_w[i]),
      .tick_o  (src_tick)
    );

    if (i % 2 == 1) begin : g_hi
      // combine bit lives in the partner (even) channel
      assign invert  = ctrl_w[i-1][CTRL_COMB_BIT];
      assign ch_tick = invert ? tc_w[i-1] : src_tick;

      p_cascade_dec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_w[i-1][CTRL_COMB_BIT] && tc_w[i-1] && en_w[i] && !load_w[i] && cnt32[i] != 0)
        |=> (cnt32[i] == $past(cnt32[i]) - 32'd1));
      p_cascade_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_w[i-1][CTRL_COMB_BIT] && !tc_w[i-1] && !load_w[i]) |=> $stable(cnt32[i]));
    end else begin : g_lo
      assign invert  = 1'b0;
      assign ch_tick = src_tick;
    end

    tmr_counter #(.W(W)) i_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_w[i]),
      .load_i   (load_w[i]),
      .tick_i   (ch_tick),
      .invert_i (invert),
      .preset_i (preset),
      .count_o  (cnt),
      .obs_o    (obs32[i]),
      .tc_o     (tc_w[i]),
      .irq_o    (irq_o[i])
    );

    assign preset32[i] = 32'(preset);
    assign cnt32[i]    = 32'(cnt);

    if (W < 32) begin : g_narrow
      p_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && hit_pre[i]) |=> (rdata_o[31:W] == '0));
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit_ctrl[c]) rd_mux = 32'(ctrl_w[c]);
      if (hit_sel[c])  rd_mux = 32'(sel_w[c]);
      if (hit_pre[c])  rd_mux = preset32[c];
      if (hit_obs[c])  rd_mux = obs32[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  p_restart_rd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && |hit_ctrl) |=> (rdata_o[CTRL_RST_BIT] == 1'b0));
endmodule

// File: tb/test_tmr_pair.sv
`timescale 1ns/1ps
module test_tmr_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  ticks = '0;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  tmr_pair i_tmr_pair (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ticks_i(ticks), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per completed read
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R1 unexpected read", rdata, 32'hx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] t = 4'b0);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; ticks = t;
    @(negedge clk); wr_en = 1'b0; ticks = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input int src, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ticks[src] = 1'b1;
      @(negedge clk); ticks[src] = 1'b0;
    end
  endtask

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8 irq idle after reset", 32'(irq), 32'h0);
    rd(8'h10, 32'h0, "R1 ctrl0 reset");
    rd(8'h48, 32'h0, "R1 obs0 reset");

    // narrow channel
    wr(8'h14, 32'hFF00_0005);
    rd(8'h14, 32'h0000_0005, "R6 narrow preset upper bits dropped");
    wr(8'h11, 32'h1);
    wr(8'h10, 32'h03);
    rd(8'h48, 32'd5, "R2 restart loads preset");
    pulse(0, 2); pulse(2, 1);
    rd(8'h48, 32'd5, "R4 unselected ticks ignored");
    pulse(1, 3);
    rd(8'h48, 32'd2, "R3 decrement per tick");
    wr(8'h10, 32'h00);
    pulse(1, 2);
    rd(8'h48, 32'd2, "R5 disabled counter frozen");
    rd(8'h10, 32'h00, "R5 enable bit cleared");
    wr(8'h10, 32'h01);
    pulse(1, 2);
    rd(8'h48, 32'd0, "R3 reaches zero");
    check("R8 no irq before terminal tick", 32'(irq), 32'h0);
    pulse(1, 1);
    check("R8 irq pulse on terminal count", 32'(irq), 32'h1);
    @(negedge clk);
    check("R8 irq single cycle", 32'(irq), 32'h0);
    rd(8'h48, 32'd5, "R3 auto reload after N+1 ticks");
    rd(8'h10, 32'h81, "R7 flag set on terminal count");
    rd(8'h10, 32'h01, "R7 flag cleared by read");

    // wide channel
    wr(8'h1C, 32'h9000_0003);
    rd(8'h1C, 32'h9000_0003, "R6 wide preset keeps all bits");
    wr(8'h19, 32'h3);
    rd(8'h19, 32'h3, "R1 tick select readback");
    wr(8'h18, 32'h03);
    rd(8'h4C, 32'h9000_0003, "R12 full-width observation");
    pulse(3, 2);
    rd(8'h4C, 32'h9000_0001, "R3 wide decrement");
    wr(8'h18, 32'h03, 4'b1000);
    rd(8'h4C, 32'h9000_0003, "R11 restart beats tick");

    // cascade
    wr(8'h1C, 32'd10);
    wr(8'h18, 32'h03);
    wr(8'h14, 32'd2);
    wr(8'h11, 32'h0);
    wr(8'h10, 32'h0B);
    rd(8'h10, 32'h09, "R1 combine bit readback");
    rd(8'h4C, 32'hFFFF_FFF5, "R10 complemented high observation");
    pulse(3, 3);
    rd(8'h4C, 32'hFFFF_FFF5, "R9 own ticks ignored when combined");
    pulse(0, 3);
    check("R8 low irq in cascade", 32'(irq), 32'h1);
    rd(8'h4C, 32'hFFFF_FFF6, "R9 high decrements once per low period");
    pulse(0, 3);
    rd(8'h4C, 32'hFFFF_FFF7, "R9 second low period");
    rd(8'h48, 32'd2, "R10 low observation not complemented");
    rd(8'h00, 32'h0, "R1 unmapped reads zero");

    repeat (2) @(negedge clk);
    check("R1 all reads returned", 32'(exp_q.size()), 32'h0);
    report();
  end
endmodule